// File: doc/BRIEF.md
# MSI Message Delivery Engine

This block sits between a device's interrupt sources and its bus-master write path. Device logic names a vector on a valid/ready request port. The engine turns each request into one single-beat 32-bit memory write that carries a 64-bit address, the message data and the device requester ID. It reads the decoded interrupt-capability fields as plain level inputs: enable, allocated vector count, address width, address words, data word, mask word and the masking-supported flag. The fabric and the register storage stay outside the block.

The engine owns the pending bits. If a request names a vector that is masked, the engine records it as pending and does not send it. A one-cycle capability-write strobe tells the engine that software has touched the capability. On that strobe, with enable and masking support both set, the engine first drops pending bits that lie outside the allocated range. It then sends every pending vector that is now unmasked, lowest vector first, and clears each one as it is sent. The pending word is an output so the register file can present it to software.

Back-pressure rules are as follows. A write request is offered with `wr_valid` and leaves on a cycle in which `wr_ready` is high. While it waits, its address, data and ID do not change. A device request is taken on a cycle in which `req_valid` and `req_ready` are both high. `req_ready` is low in three cases: while an unaccepted write occupies the output, while a replay is running, and during the strobe cycle. Replays therefore finish before any request that arrives after the strobe. Each accepted request produces at most one write.

Top module: `msi_deliver`

## Requirements
- R1: After reset, `wr_valid` is low, every pending bit is zero and `req_ready` is high.
- R2: The allocated count is N = 2^L, where L is `cfg_log_vec`, clamped to log2(MAX_VEC). For N > 1, bits [L-1:0] of `wr_data` hold the vector number and the higher bits come from `cfg_data`. For N = 1, `wr_data` equals `cfg_data`. Bits [31:16] of `wr_data` are always zero. A request with enable set must name a vector below N.
- R3: With `cfg_addr64` high, `wr_addr` is {`cfg_addr_hi`, `cfg_addr_lo`}. With it low, `wr_addr` is `cfg_addr_lo` with bits [63:32] zero. `wr_rid` equals `dev_rid`.
- R4: With enable and masking support set, a request for a vector whose `cfg_mask` bit is 1 sets that vector's pending bit and issues no write.
- R5: With masking support clear, `cfg_mask` has no effect, every request is sent, and the pending word reads zero.
- R6: A request accepted while enable is clear issues no write and leaves the pending word unchanged.
- R7: On a strobe with enable and masking support set, the pending bits at index N or above are cleared.
- R8: After that trim, each pending vector that is unmasked is sent and its pending bit cleared, in ascending vector order. Pending vectors that are still masked stay pending.
- R9: A strobe while enable is clear neither trims nor replays.
- R10: While `wr_valid` is high and `wr_ready` is low, the write fields stay stable and `req_ready` is low. `req_ready` is also low during the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Message delivery enabled |
| cfg_log_vec | input | LOG_W | log2 of the allocated vector count |
| cfg_addr64 | input | 1 | 64-bit address mode |
| cfg_addr_lo | input | 32 | Address low word |
| cfg_addr_hi | input | 32 | Address high word |
| cfg_data | input | 16 | Message data base value |
| cfg_mask_cap | input | 1 | Per-vector masking supported |
| cfg_mask | input | MAX_VEC | Per-vector mask bits |
| cfg_write | input | 1 | One-cycle strobe: the capability was written |
| dev_rid | input | 16 | Requester ID |
| req_valid | input | 1 | Vector request valid |
| req_ready | output | 1 | Vector request accepted |
| req_vec | input | log2(MAX_VEC) | Requested vector |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Fabric takes the write |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data (little-endian dword) |
| wr_rid | output | 16 | Requester ID tag |
| pend_bits | output | MAX_VEC | Pending vector bits |

## Verification
The bench builds the engine with MAX_VEC = 8 and LOG_W = 3. At that size it can sweep every allocated count from one to eight vectors, plus a count setting above the maximum that must clamp. It requests every legal vector under two data patterns in both address widths. With eight vectors it can fill the whole pending word, trim it with a smaller count and watch the ascending replay order in full. It also covers the masking-unsupported case, the enable-clear case and a stalled output.

// File: rtl/msi_dlv_pkg.sv
package msi_dlv_pkg;

  // Width of the device requester ID carried with every write.
  localparam int RID_W = 16;

  // One outgoing message write.
  typedef struct packed {
    logic [63:0]      addr;
    logic [31:0]      data;
    logic [RID_W-1:0] rid;
  } msi_msg_t;

endpackage

// File: rtl/msi_dlv_fmt.sv
module msi_dlv_fmt
  import msi_dlv_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int LOG_W = 3
) (
  input  logic [LOG_W-1:0] log_n,      // already clamped
  input  logic [VEC_W-1:0] vec,
  input  logic [15:0]      base_data,
  input  logic             addr64,
  input  logic [31:0]      addr_lo,
  input  logic [31:0]      addr_hi,
  input  logic [RID_W-1:0] rid,
  output msi_msg_t         msg
);

  logic [15:0] low_mask;
  logic [15:0] data16;

  always_comb begin
    low_mask = (16'd1 << log_n) - 16'd1;
    data16   = (base_data & ~low_mask) | (16'(vec) & low_mask);
    msg.data = {16'h0000, data16};
    msg.addr = addr64 ? {addr_hi, addr_lo} : {32'h0000_0000, addr_lo};
    msg.rid  = rid;
  end

endmodule

// File: rtl/msi_dlv_pend.sv
module msi_dlv_pend #(
  parameter int NV = 32,
  localparam int VW = $clog2(NV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,     // masking unsupported: no pending state
  input  logic          set_en,
  input  logic [VW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [VW-1:0] clr_idx,
  input  logic          trim_en,
  input  logic [NV-1:0] keep,      // ones below the allocated count
  output logic [NV-1:0] pend
);

  logic [NV-1:0] nxt;

  always_comb begin
    nxt = pend;
    if (trim_en) nxt = nxt & keep;
    if (clr_en)  nxt[clr_idx] = 1'b0;
    if (set_en)  nxt[set_idx] = 1'b1;
    if (flush)   nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt;
  end

  // R7: after a trim nothing remains outside the allocated range
  a_r7_trim: assert property (@(posedge clk) disable iff (!rst_n)
    trim_en |=> (pend & ~$past(keep)) == '0);

  // R8: a replay clear really removes the bit
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !set_en |=> !pend[$past(clr_idx)]);

endmodule

// File: rtl/msi_dlv_scan.sv
module msi_dlv_scan #(
  parameter int NV = 32,
  localparam int VW = $clog2(NV)
) (
  input  logic [NV-1:0] pend,
  input  logic [NV-1:0] mask,
  input  logic [NV-1:0] keep,
  output logic          found,
  output logic [VW-1:0] idx
);

  logic [NV-1:0] cand;

  assign cand  = pend & ~mask & keep;
  assign found = |cand;

  // Lowest candidate wins.
  always_comb begin
    idx = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (cand[i]) idx = VW'(i);
    end
  end

endmodule

// File: rtl/msi_deliver.sv
module msi_deliver
  import msi_dlv_pkg::*;
#(
  parameter int MAX_VEC = 32,
  parameter int LOG_W   = 3,
  localparam int VW      = $clog2(MAX_VEC),
  localparam int LOG_MAX = VW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [LOG_W-1:0]   cfg_log_vec,
  input  logic               cfg_addr64,
  input  logic [31:0]        cfg_addr_lo,
  input  logic [31:0]        cfg_addr_hi,
  input  logic [15:0]        cfg_data,
  input  logic               cfg_mask_cap,
  input  logic [MAX_VEC-1:0] cfg_mask,
  input  logic               cfg_write,
  input  logic [RID_W-1:0]   dev_rid,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VW-1:0]      req_vec,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [63:0]        wr_addr,
  output logic [31:0]        wr_data,
  output logic [RID_W-1:0]   wr_rid,
  output logic [MAX_VEC-1:0] pend_bits
);

  logic [LOG_W-1:0]   eff_log;
  logic [MAX_VEC-1:0] keep;
  logic [MAX_VEC-1:0] eff_mask;
  logic               slot_free, req_fire, req_masked, req_send, set_en;
  logic               trim_en, busy_q, found, rep_send, load;
  logic [VW-1:0]      pick, sel_vec;
  msi_msg_t           msg_d, msg_q;
  logic               wr_valid_q;

  // Allocated count, clamped to what the block can hold.
  assign eff_log = (cfg_log_vec > LOG_W'(LOG_MAX)) ? LOG_W'(LOG_MAX) : cfg_log_vec;

  for (genvar g = 0; g < MAX_VEC; g++) begin : g_keep
    assign keep[g] = (32'(g) >> eff_log) == 32'd0;
  end

  assign eff_mask   = cfg_mask_cap ? cfg_mask : '0;
  assign slot_free  = !wr_valid_q || wr_ready;
  assign req_ready  = !busy_q && !cfg_write && slot_free;
  assign req_fire   = req_valid && req_ready;
  assign req_masked = eff_mask[req_vec];
  assign req_send   = req_fire && cfg_enable && !req_masked;
  assign set_en     = req_fire && cfg_enable && req_masked;
  assign trim_en    = cfg_write && cfg_enable && cfg_mask_cap;

  msi_dlv_pend #(.NV(MAX_VEC)) i_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!cfg_mask_cap),
    .set_en  (set_en),
    .set_idx (req_vec),
    .clr_en  (rep_send),
    .clr_idx (pick),
    .trim_en (trim_en),
    .keep    (keep),
    .pend    (pend_bits)
  );

  msi_dlv_scan #(.NV(MAX_VEC)) i_scan (
    .pend  (pend_bits),
    .mask  (eff_mask),
    .keep  (keep),
    .found (found),
    .idx   (pick)
  );

  assign rep_send = busy_q && found && slot_free && cfg_enable;
  assign load     = req_send || rep_send;
  assign sel_vec  = busy_q ? pick : req_vec;

  msi_dlv_fmt #(.VEC_W(VW), .LOG_W(LOG_W)) i_fmt (
    .log_n     (eff_log),
    .vec       (sel_vec),
    .base_data (cfg_data),
    .addr64    (cfg_addr64),
    .addr_lo   (cfg_addr_lo),
    .addr_hi   (cfg_addr_hi),
    .rid       (dev_rid),
    .msg       (msg_d)
  );

  // Replay runs from the strobe until no sendable pending vector remains.
  always_ff @(posedge clk) begin
    if (!rst_n)                               busy_q <= 1'b0;
    else if (trim_en)                         busy_q <= 1'b1;
    else if (busy_q && (!found || !cfg_enable)) busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_q <= 1'b0;
      msg_q      <= '0;
    end else if (load) begin
      wr_valid_q <= 1'b1;
      msg_q      <= msg_d;
    end else if (wr_ready) begin
      wr_valid_q <= 1'b0;
    end
  end

  assign wr_valid = wr_valid_q;
  assign wr_addr  = msg_q.addr;
  assign wr_data  = msg_q.data;
  assign wr_rid   = msg_q.rid;

  // R10: a stalled write holds its fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_rid));

  // R2: requests name a vector below the allocated count
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_enable |-> (32'(req_vec) >> eff_log) == 32'd0);

  // R2: upper half of the message data is zero
  a_r2_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[31:16] == 16'h0000);

  // R4: a masked request only records a pending bit
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_bits[$past(req_vec)] && !wr_valid);

  // R5: no pending state without masking support
  a_r5_nopend: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mask_cap |=> pend_bits == '0);

  // R6: a request taken while disabled changes nothing
  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !cfg_enable && cfg_mask_cap |=> !wr_valid && pend_bits == $past(pend_bits));

endmodule

// File: tb/test_msi_deliver.sv
`timescale 1ns/1ps
module test_msi_deliver;
  localparam int NV = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b1;
  logic [2:0] cfg_log_vec = 3'd0;
  logic cfg_addr64 = 1'b0;
  logic [31:0] cfg_addr_lo = 32'hFEE0_1000;
  logic [31:0] cfg_addr_hi = 32'h0000_0001;
  logic [15:0] cfg_data = 16'h4A5B;
  logic cfg_mask_cap = 1'b0;
  logic [NV-1:0] cfg_mask = '0;
  logic cfg_write = 1'b0;
  logic [15:0] dev_rid = 16'hBEEF;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VW-1:0] req_vec = '0;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic [15:0] wr_rid;
  logic [NV-1:0] pend_bits;

  always #2.5 clk = ~clk;

  msi_deliver #(.MAX_VEC(NV), .LOG_W(3)) i_msi_deliver (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vec(cfg_log_vec),
    .cfg_addr64(cfg_addr64), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_data(cfg_data), .cfg_mask_cap(cfg_mask_cap), .cfg_mask(cfg_mask),
    .cfg_write(cfg_write), .dev_rid(dev_rid), .req_valid(req_valid),
    .req_ready(req_ready), .req_vec(req_vec), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_rid(wr_rid),
    .pend_bits(pend_bits)
  );

  int n_chk = 0;
  int n_bad = 0;
  int got_n = 0;
  logic done = 1'b0;
  logic [63:0] g_addr [0:255];
  logic [31:0] g_data [0:255];
  logic [15:0] g_rid  [0:255];

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && got_n < 256) begin
      g_addr[got_n] <= wr_addr;
      g_data[got_n] <= wr_data;
      g_rid[got_n]  <= wr_rid;
      got_n <= got_n + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merged(input logic [15:0] d, input int lg, input int v);
    int l;
    logic [15:0] m;
    l = (lg > 3) ? 3 : lg;
    m = 16'((1 << l) - 1);
    return {16'h0000, (d & ~m) | (16'(v) & m)};
  endfunction

  task automatic send(input int v);
    @(negedge clk);
    req_valid = 1'b1;
    req_vec = VW'(v);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); cfg_write = 1'b1;
    @(negedge clk); cfg_write = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [15:0] pats [0:1];
    logic [31:0] held;
    pats[0] = 16'h4A5B;
    pats[1] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_valid", 64'(wr_valid), 64'd0);
    chk("R1 pend", 64'(pend_bits), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);

    // R2/R3 sweep: counts 1..8 plus clamped setting, both address widths
    for (int a = 0; a < 2; a++) begin
      for (int p = 0; p < 2; p++) begin
        for (int lg = 0; lg < 6; lg++) begin
          int cnt;
          cnt = 1 << ((lg > 3) ? 3 : lg);
          cfg_addr64 = a[0];
          cfg_data = pats[p];
          cfg_log_vec = 3'(lg);
          for (int v = 0; v < cnt; v++) begin
            base = got_n;
            send(v);
            repeat (2) @(negedge clk);
            chk("R2 one write", 64'(got_n), 64'(base + 1));
            chk("R2 data", 64'(g_data[base]), 64'(merged(pats[p], lg, v)));
            chk("R3 addr", g_addr[base], a ? {cfg_addr_hi, cfg_addr_lo} : {32'h0, cfg_addr_lo});
            chk("R3 rid", 64'(g_rid[base]), 64'(dev_rid));
          end
        end
      end
    end
    cfg_addr64 = 1'b0;
    cfg_data = 16'h4A5B;

    // R5: mask ignored without masking support
    cfg_mask_cap = 1'b0; cfg_mask = 8'hFF; cfg_log_vec = 3'd3;
    base = got_n;
    send(4);
    repeat (2) @(negedge clk);
    chk("R5 sent despite mask", 64'(got_n), 64'(base + 1));
    chk("R5 data", 64'(g_data[base]), 64'(merged(16'h4A5B, 3, 4)));
    chk("R5 pend zero", 64'(pend_bits), 64'd0);

    // R4: every vector masked -> pending
    cfg_mask_cap = 1'b1;
    base = got_n;
    for (int v = 0; v < NV; v++) begin
      send(v);
      repeat (2) @(negedge clk);
      chk("R4 pend bit", 64'(pend_bits[v]), 64'd1);
    end
    chk("R4 no writes", 64'(got_n), 64'(base));
    chk("R4 pend all", 64'(pend_bits), 64'hFF);

    // R7/R8: shrink to 4 vectors, unmask all but vector 1
    cfg_log_vec = 3'd2; cfg_mask = 8'h02;
    base = got_n;
    strobe();
    settle();
    chk("R8 replay count", 64'(got_n), 64'(base + 3));
    chk("R8 first v0", 64'(g_data[base]),     64'(merged(16'h4A5B, 2, 0)));
    chk("R8 second v2", 64'(g_data[base + 1]), 64'(merged(16'h4A5B, 2, 2)));
    chk("R8 third v3", 64'(g_data[base + 2]), 64'(merged(16'h4A5B, 2, 3)));
    chk("R7 trimmed, R8 masked kept", 64'(pend_bits), 64'h02);
    cfg_mask = 8'h00;
    base = got_n;
    strobe();
    settle();
    chk("R8 replay v1", 64'(got_n), 64'(base + 1));
    chk("R8 data v1", 64'(g_data[base]), 64'(merged(16'h4A5B, 2, 1)));
    chk("R8 pend empty", 64'(pend_bits), 64'd0);

    // R9 / R6: disabled behaviour
    cfg_log_vec = 3'd3; cfg_mask = 8'hFF;
    send(5); send(6);
    repeat (2) @(negedge clk);
    chk("R4 pend 5,6", 64'(pend_bits), 64'h60);
    cfg_enable = 1'b0; cfg_mask = 8'h00; cfg_log_vec = 3'd2;
    base = got_n;
    send(3);
    repeat (2) @(negedge clk);
    chk("R6 no write", 64'(got_n), 64'(base));
    chk("R6 pend unchanged", 64'(pend_bits), 64'h60);
    strobe();
    settle();
    chk("R9 no replay", 64'(got_n), 64'(base));
    chk("R9 no trim", 64'(pend_bits), 64'h60);
    cfg_enable = 1'b1;
    strobe();
    settle();
    chk("R7 trim drops 5,6", 64'(pend_bits), 64'd0);
    chk("R7 nothing sent", 64'(got_n), 64'(base));

    // R10: back-pressure
    cfg_mask_cap = 1'b0; cfg_log_vec = 3'd3;
    @(negedge clk);
    cfg_write = 1'b1;
    #0.1 chk("R10 ready low on strobe", 64'(req_ready), 64'd0);
    @(negedge clk); cfg_write = 1'b0;
    wr_ready = 1'b0;
    base = got_n;
    send(2);
    @(negedge clk);
    chk("R10 valid", 64'(wr_valid), 64'd1);
    chk("R10 ready low", 64'(req_ready), 64'd0);
    held = wr_data;
    repeat (3) @(negedge clk);
    chk("R10 still valid", 64'(wr_valid), 64'd1);
    chk("R10 data held", 64'(wr_data), 64'(held));
    chk("R10 not taken", 64'(got_n), 64'(base));
    wr_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 taken once", 64'(got_n), 64'(base + 1));
    chk("R10 data", 64'(g_data[base]), 64'(merged(16'h4A5B, 3, 2)));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule